// File: doc/BRIEF.md
# Instruction Format Decoder with Indexed Addressing

This block sits behind an instruction fetch stage and takes a stream of 16-bit halfwords. It splits the first halfword of each instruction into an opcode, a first register field and a second 4-bit field, then sorts the opcode into one of four formats using a fixed table keyed on the top two opcode bits. Register-register and short-immediate instructions are one halfword long and complete at once. Register-memory and register-storage instructions are two halfwords long. For these, the decoder waits for the address halfword and forms a 16-bit effective address. If the second field names a register other than 0, it adds that register's contents to the address.

The decoder reads the index register through a small combinational port: it presents the register number on `idx_addr` and takes the register value on `idx_data` in the same cycle. A model-select input sets how many instruction groups are legal. An opcode outside the enabled groups still takes its full length, but its completion is marked invalid so that the core can stop.

Top module: `instr_fmt_decoder`

## Requirements
- R1: Bits 15 down to 8 of the first halfword (bit 15 is the most significant) appear on `dec_op`, bits 7..4 on `dec_r1`, and bits 3..0 on `dec_f2`, all valid while `dec_done` is high.
- R2: The format tag on `dec_fmt` comes from opcode bits 7..6: 00 gives register-register (tag 0), 11 gives short immediate (tag 1), 01 gives register-memory (tag 2), and 10 gives register-storage (tag 3).
- R3: A register-register or short instruction raises `dec_done` for one cycle, in the cycle after its halfword is accepted, with `dec_ea` equal to 0.
- R4: A register-memory or register-storage instruction does not raise `dec_done` after its first halfword. It raises `dec_done` in the cycle after its second halfword is accepted.
- R5: When the second field (RX) is non-zero, `dec_ea` is the address halfword plus the contents of register RX, truncated to 16 bits so that it wraps modulo 65536. The register is read through `idx_addr`/`idx_data`.
- R6: When RX is 0, `dec_ea` equals the address halfword, whatever register 0 holds.
- R7: Opcode bits 5..3 select the group. Values 0, 1 and 2 are base (group 0). Value 3 is block load/store and single floating point (group 1). Values 4 and 5 are extended (group 2). Value 6 is double floating point (group 3). Value 7 is memory extension (group 4). An opcode is legal when its group is not greater than `model_sel`, so values 4 to 7 enable every group.
- R8: `dec_invalid` is high with `dec_done` exactly for illegal opcodes. An illegal instruction still consumes the number of halfwords its format sets.
- R9: During and after reset, `dec_done` and `dec_invalid` are low, `dec_ea` is 0, and the next accepted halfword is treated as a first halfword.
- R10: While `hw_valid` is low nothing is accepted. A pending address halfword is waited for without limit, and `dec_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | A halfword is offered on hw_data this cycle |
| hw_data | input | 16 | Instruction halfword |
| model_sel | input | 3 | Highest enabled instruction group |
| idx_data | input | 16 | Contents of the register named by idx_addr |
| idx_addr | output | 4 | Index register number being read |
| dec_done | output | 1 | One-cycle strobe: an instruction is fully decoded |
| dec_op | output | 8 | Opcode |
| dec_r1 | output | 4 | First register field |
| dec_f2 | output | 4 | Second field (R2, N or RX) |
| dec_fmt | output | 2 | Format tag |
| dec_ea | output | 16 | Effective address (0 for one-halfword formats) |
| dec_invalid | output | 1 | Opcode illegal for the selected model |

## Verification
The bench aims at index register 0 holding a non-zero value. A design that indexed through it anyway would return a shifted address. It also sends an address whose indexed sum passes 0xFFFF, which catches an adder that is too wide or that saturates. Address halfwords arrive both back to back and after long idle gaps, so a decoder that signalled completion early or lost its sequence state would produce extra or misplaced completions. Every group boundary is checked under each model value, and one illegal two-halfword opcode is included. A legality table off by one group, or an invalid instruction that drops its address halfword, then shows up in the following instructions.

// File: rtl/instr_fmt_decoder.sv
module instr_fmt_decoder #(
  parameter int HW  = 16,
  parameter int OPW = 8,
  parameter int RW  = 4,
  parameter int MSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hw_valid,
  input  logic [HW-1:0]  hw_data,
  input  logic [MSW-1:0] model_sel,
  input  logic [HW-1:0]  idx_data,
  output logic [RW-1:0]  idx_addr,
  output logic           dec_done,
  output logic [OPW-1:0] dec_op,
  output logic [RW-1:0]  dec_r1,
  output logic [RW-1:0]  dec_f2,
  output logic [1:0]     dec_fmt,
  output logic [HW-1:0]  dec_ea,
  output logic           dec_invalid
);
  localparam logic [1:0] FMT_RR = 2'd0, FMT_SF = 2'd1, FMT_RM = 2'd2, FMT_RS = 2'd3;

  logic st_addr_q;

  wire [OPW-1:0] op_in  = hw_data[HW-1 -: OPW];
  wire [1:0]     cls    = op_in[OPW-1 -: 2];
  wire           two_hw = (cls == 2'b01) || (cls == 2'b10);

  logic [1:0] fmt_in;
  always_comb begin
    case (cls)
      2'b00:   fmt_in = FMT_RR;
      2'b11:   fmt_in = FMT_SF;
      2'b01:   fmt_in = FMT_RM;
      default: fmt_in = FMT_RS;
    endcase
  end

  wire [OPW-1:0] op_chk = st_addr_q ? dec_op : op_in;
  wire [2:0]     sub    = op_chk[OPW-3 -: 3];

  logic [MSW-1:0] grp;
  always_comb begin
    case (sub)
      3'd0, 3'd1, 3'd2: grp = MSW'(0);
      3'd3:             grp = MSW'(1);
      3'd4, 3'd5:       grp = MSW'(2);
      3'd6:             grp = MSW'(3);
      default:          grp = MSW'(4);
    endcase
  end

  wire legal = (grp <= model_sel);

  assign idx_addr = dec_f2;
  wire [HW-1:0] ea_next = hw_data + ((dec_f2 != '0) ? idx_data : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_addr_q   <= 1'b0;
      dec_done    <= 1'b0;
      dec_op      <= '0;
      dec_r1      <= '0;
      dec_f2      <= '0;
      dec_fmt     <= FMT_RR;
      dec_ea      <= '0;
      dec_invalid <= 1'b0;
    end else begin
      dec_done <= 1'b0;
      if (hw_valid) begin
        if (!st_addr_q) begin
          dec_op  <= op_in;
          dec_r1  <= hw_data[HW-OPW-1 -: RW];
          dec_f2  <= hw_data[RW-1:0];
          dec_fmt <= fmt_in;
          if (two_hw) begin
            st_addr_q <= 1'b1;
          end else begin
            dec_done    <= 1'b1;
            dec_ea      <= '0;
            dec_invalid <= !legal;
          end
        end else begin
          st_addr_q   <= 1'b0;
          dec_ea      <= ea_next;
          dec_done    <= 1'b1;
          dec_invalid <= !legal;
        end
      end
    end
  end
endmodule

module instr_fmt_decoder_chk #(
  parameter int HW  = 16,
  parameter int OPW = 8,
  parameter int RW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hw_valid,
  input logic [HW-1:0]  hw_data,
  input logic [HW-1:0]  idx_data,
  input logic [RW-1:0]  idx_addr,
  input logic           in_addr,
  input logic           dec_done,
  input logic [OPW-1:0] dec_op,
  input logic [1:0]     dec_fmt,
  input logic [HW-1:0]  dec_ea,
  input logic           dec_invalid
);
  p_idx_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && in_addr && idx_addr != '0) |=> (dec_done && dec_ea == HW'($past(hw_data) + $past(idx_data))));

  p_no_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && in_addr && idx_addr == '0) |=> (dec_done && dec_ea == $past(hw_data)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_valid |=> !dec_done);

  p_second_hw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_done && dec_fmt[1]) |-> $past(in_addr && hw_valid));

  p_short_ea_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_done && !dec_fmt[1]) |-> (dec_ea == '0));

  p_base_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_done && dec_op[OPW-3 -: 3] < 3'd3) |-> !dec_invalid);
endmodule

bind instr_fmt_decoder instr_fmt_decoder_chk #(.HW(HW), .OPW(OPW), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
  .idx_data(idx_data), .idx_addr(idx_addr), .in_addr(st_addr_q),
  .dec_done(dec_done), .dec_op(dec_op), .dec_fmt(dec_fmt),
  .dec_ea(dec_ea), .dec_invalid(dec_invalid)
);

// File: tb/instr_fmt_decoder_tb.sv
module instr_fmt_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0;
  logic [15:0] hw_data = '0;
  logic [2:0]  model_sel = 3'd4;
  logic [15:0] idx_data;
  logic [3:0]  idx_addr;
  logic        dec_done, dec_invalid;
  logic [7:0]  dec_op;
  logic [3:0]  dec_r1, dec_f2;
  logic [1:0]  dec_fmt;
  logic [15:0] dec_ea;

  always #2.5 clk = ~clk;

  logic [15:0] regs [16];
  assign idx_data = regs[idx_addr];

  instr_fmt_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
    .model_sel(model_sel), .idx_data(idx_data), .idx_addr(idx_addr),
    .dec_done(dec_done), .dec_op(dec_op), .dec_r1(dec_r1), .dec_f2(dec_f2),
    .dec_fmt(dec_fmt), .dec_ea(dec_ea), .dec_invalid(dec_invalid)
  );

  typedef struct {
    logic [7:0]  op;
    logic [3:0]  r1, f2;
    logic [1:0]  fmt;
    logic [15:0] ea;
    logic        inv;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv, string what);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [1:0] fmt_of(logic [7:0] op);
    case (op[7:6])
      2'b00: return 2'd0;
      2'b11: return 2'd1;
      2'b01: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic int grp_of(logic [7:0] op);
    case (op[5:3])
      3'd0, 3'd1, 3'd2: return 0;
      3'd3: return 1;
      3'd4, 3'd5: return 2;
      3'd6: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic send(logic [15:0] w);
    hw_valid = 1'b1;
    hw_data  = w;
    @(negedge clk);
    hw_valid = 1'b0;
    hw_data  = '0;
  endtask

  task automatic instr(logic [7:0] op, logic [3:0] r1, logic [3:0] f2,
                       logic [15:0] addr, int gap, string req);
    exp_t e;
    e.op = op; e.r1 = r1; e.f2 = f2; e.fmt = fmt_of(op);
    e.inv = (grp_of(op) > int'(model_sel));
    e.ea = '0;
    if (e.fmt[1]) e.ea = (f2 != 0) ? 16'(addr + regs[f2]) : addr;
    e.req = req;
    exp_q.push_back(e);
    send({op, r1, f2});
    if (e.fmt[1]) begin
      repeat (gap) @(negedge clk);
      send(addr);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dec_done) begin
      if (exp_q.size() == 0) begin
        check("R4", 32'(dec_done), 32'd0, "unexpected done");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.req, "/R1"}, {dec_op, dec_r1, dec_f2}, {e.op, e.r1, e.f2}, "fields");
        check({e.req, "/R2"}, 32'(dec_fmt), 32'(e.fmt), "fmt");
        check({e.req, "/R5"}, 32'(dec_ea), 32'(e.ea), "ea");
        check({e.req, "/R8"}, 32'(dec_invalid), 32'(e.inv), "invalid");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 16'h1111 * 16'(i) + 16'h0203;
    regs[0] = 16'hBEEF;
    regs[5] = 16'h0020;
    hw_valid = 1'b1;
    hw_data  = 16'h4512;
    repeat (4) @(negedge clk);
    // R9: reset holds outputs and ignores offered halfwords
    check("R9", {dec_done, dec_invalid}, 0, "done/invalid in reset");
    check("R9", 32'(dec_ea), 0, "ea in reset");
    hw_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", 32'(dec_done), 0, "done after reset");

    model_sel = 3'd4;
    // R3 register-register and short formats
    instr(8'h05, 4'h3, 4'h9, 0, 0, "R3");
    instr(8'hC2, 4'hA, 4'h7, 0, 0, "R3");
    instr(8'h13, 4'hF, 4'h0, 0, 0, "R3");
    // R5 indexed memory formats, R6 with RX zero
    instr(8'h48, 4'h1, 4'h3, 16'h1000, 0, "R5");
    instr(8'h88, 4'h2, 4'h5, 16'hFFF0, 0, "R5");
    instr(8'h50, 4'h4, 4'h0, 16'h2345, 0, "R6");
    instr(8'h90, 4'h6, 4'h0, 16'hFFFF, 0, "R6");
    // R10 / R4: long gap before the address halfword
    instr(8'h41, 4'h7, 4'hC, 16'h8000, 9, "R10");
    repeat (6) @(negedge clk);
    instr(8'hB9, 4'h8, 4'h5, 16'hFFE0, 3, "R4");
    // R7 / R8: legality across models
    for (int m = 0; m < 5; m++) begin
      model_sel = 3'(m);
      for (int s = 0; s < 8; s++) begin
        instr({2'b00, 3'(s), 3'd1}, 4'h2, 4'h4, 0, 0, "R7");
      end
      instr({2'b01, 3'd7, 3'd0}, 4'h3, 4'h2, 16'h0100, 1, "R8");
      instr(8'hC0, 4'h1, 4'h1, 0, 0, "R8");
    end
    model_sel = 3'd7;
    instr(8'h3F, 4'h5, 4'h5, 0, 0, "R7");
    repeat (5) @(negedge clk);
    check("R4", exp_q.size(), 0, "outstanding completions");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule